// File: doc/BRIEF.md
# Reloadable DMA Channel Engine

This block is one DMA channel. It copies data from a source address to a destination address over a simple request/grant memory bus. Each unit of work is one read at the source width, then one write at the destination width. Software sets the channel up through a small register port. It writes the pointers, a byte count, the two widths, the increment enables, a request mode and a burst length, and then issues a start command.

When the byte count reaches zero, the channel checks its reload count. If the reload count is non-zero, the channel copies the reload source, reload destination and reload count into its working registers and carries on without a pause. If the reload count is zero, the channel stops. Two sticky flags record these events, one for count-to-zero and one for channel-disabled. Each flag has its own interrupt enable.

In the peripheral modes the transfer is paced by a request input, and one side of the copy is fixed at the peripheral data port address.

Top module: `dma_reload_chan`

## Requirements
- R1: After reset the channel is idle with `bus_req` low and `irq` low. Every register reads zero.
- R2: One unit is one read followed by one write. Both the read and the write hold their request with a stable address, direction and size until they are granted. Size codes 0, 1 and 2 mean 1, 2 and 4 bytes, and data is carried in the low bits. The write carries the low destination-width bits of the source-width read data, zero-extended. The configuration register (offset 0) holds the source width in bits [1:0] and the destination width in bits [3:2].
- R3: If its increment enable is set, the source pointer advances by the source width in bytes and the destination pointer advances by the destination width in bytes. Configuration bit 4 is the source increment enable and bit 5 the destination increment enable. A pointer whose enable is clear stays constant.
- R4: Each granted write lowers the byte count by the destination width in bytes. If fewer bytes than that remain, the count becomes zero.
- R5: When the count reaches zero and the reload count is non-zero, the channel loads the reload source, reload destination and reload count into the working registers and keeps running. This sets the count-to-zero flag only.
- R6: When the count reaches zero and the reload count is zero, the channel stops, `bus_req` drops, and both flags are set.
- R7: Configuration bits [7:6] select the request mode. In mode 0 (memory to memory) the channel runs without `per_req`. In mode 1 every read goes to `PORT_ADDR`, and in mode 2 every write goes to `PORT_ADDR`. The pointer on the port side does not move.
- R8: In modes 1 and 2, the channel waits for `per_req` before each burst of (configuration bits [12:8] + 1) bytes. While it waits, no bus request is made.
- R9: Writing bit 1 of the command register (offset 1) stops the channel. `bus_req` is low from the next cycle, and the channel-disabled flag is set. A transfer granted in the stop cycle still updates the pointers and the count.
- R10: Writing bit 0 of the command register starts the channel. If the count is zero at that moment, the channel-disabled flag is set at once and no bus request is made. Reading offset 1 returns 1 in bit 0 while the channel runs.
- R11: The flags register is at offset 8. Bit 0 is count-to-zero and bit 1 is channel-disabled. The flags are sticky and are cleared by writing one. If a flag is set in the same cycle that it is cleared, the set wins.
- R12: `irq` is high when a flag is set and its enable is set. Configuration bit 16 enables count-to-zero and bit 17 enables channel-disabled.
- R13: While the channel runs, writes to the source (offset 2), destination (offset 3), count (offset 4) and the transfer fields of the configuration register are ignored. The reload registers (offsets 5, 6 and 7) and the two enable bits can be written at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| per_req | input | 1 | Peripheral request for one burst |
| bus_req | output | 1 | Bus transaction request |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | AW | Byte address |
| bus_size | output | 2 | Transfer size code |
| bus_wdata | output | 32 | Write data, low-aligned |
| bus_gnt | input | 1 | Grant; the transaction completes in this cycle |
| bus_rdata | input | 32 | Read data, valid with the grant |
| irq | output | 1 | Channel interrupt |

## Verification
Two pairs of events can fall in the same cycle, and the bench drives each pair together on purpose.

- **Stop against the final write.** A stop command can arrive in the same cycle as the grant of the final write. The bench uses zero-wait grants and a one-byte transfer, so the final write grant lands two cycles after the start. It places the stop command on exactly that edge. The result is correct when the byte has been written, the count reads zero, both flags are set and the channel is idle.
- **Flag clear against flag set.** A clear-by-one of the flags register can arrive in the same cycle as the flag-setting event. The bench places the clear write on the same edge as the final write grant. The result is correct when the flags still read 3 afterwards.

// File: rtl/dma_reload_chan.sv
module dma_reload_chan #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int BW = 5,
  parameter logic [AW-1:0] PORT_ADDR = 32'h4000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          per_req,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic [31:0]   bus_wdata,
  input  logic          bus_gnt,
  input  logic [31:0]   bus_rdata,
  output logic          irq
);
  localparam int BLW = BW + 1;
  localparam logic [1:0] S_IDLE = 2'd0, S_WAIT = 2'd1, S_RD = 2'd2, S_WR = 2'd3;

  function automatic logic [2:0] nbytes(input logic [1:0] w);
    return (w == 2'd0) ? 3'd1 : (w == 2'd1) ? 3'd2 : 3'd4;
  endfunction

  function automatic logic [31:0] wmask(input logic [1:0] w);
    return (w == 2'd0) ? 32'h0000_00FF : (w == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [1:0] wclamp(input logic [1:0] w);
    return (w == 2'd3) ? 2'd2 : w;
  endfunction

  logic [1:0]    st;
  logic [1:0]    src_w, dst_w, mode;
  logic          src_inc, dst_inc, ctz_ie, dis_ie;
  logic [BW-1:0] burst_m1;
  logic [AW-1:0] src, dst, rsrc, rdst;
  logic [CW-1:0] cnt, rcnt;
  logic [BLW-1:0] bleft;
  logic [31:0]   hold;
  logic          f_ctz, f_dis;

  wire idle     = (st == S_IDLE);
  wire wr_cfg   = reg_we && reg_addr == 4'd0;
  wire wr_cmd   = reg_we && reg_addr == 4'd1;
  wire stop_cmd = wr_cmd && reg_wdata[1];
  wire start_cmd = wr_cmd && reg_wdata[0] && !reg_wdata[1];
  wire wr_flags = reg_we && reg_addr == 4'd8;

  wire [2:0]    sb = nbytes(src_w);
  wire [2:0]    db = nbytes(dst_w);
  wire [CW-1:0] db_ext = CW'(db);
  wire          last = (cnt <= db_ext);
  wire [CW-1:0] cnt_next = last ? '0 : cnt - db_ext;
  wire          rd_done = (st == S_RD) && bus_gnt;
  wire          wr_done = (st == S_WR) && bus_gnt;
  wire          reload_go = wr_done && last && (rcnt != '0);
  wire          finish = wr_done && last && (rcnt == '0);
  wire [BLW-1:0] burst_bytes = BLW'(burst_m1) + BLW'(1);
  wire          burst_end = (bleft <= BLW'(db));
  wire [1:0]    run_state = (mode == 2'd0) ? S_RD : S_WAIT;
  wire          go = idle && start_cmd && (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_IDLE;
    else if (stop_cmd) st <= S_IDLE;
    else begin
      case (st)
        S_IDLE: if (go) st <= run_state;
        S_WAIT: if (per_req) st <= S_RD;
        S_RD:   if (bus_gnt) st <= S_WR;
        default: if (bus_gnt) begin
          if (finish) st <= S_IDLE;
          else if (last) st <= run_state;
          else if (mode != 2'd0 && burst_end) st <= S_WAIT;
          else st <= S_RD;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bleft <= '0;
    else if (go || reload_go || (wr_done && burst_end)) bleft <= burst_bytes;
    else if (wr_done) bleft <= bleft - BLW'(db);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_w <= '0; dst_w <= '0; mode <= '0;
      src_inc <= 1'b0; dst_inc <= 1'b0; burst_m1 <= '0;
      ctz_ie <= 1'b0; dis_ie <= 1'b0;
    end else if (wr_cfg) begin
      ctz_ie <= reg_wdata[16];
      dis_ie <= reg_wdata[17];
      if (idle) begin
        src_w    <= wclamp(reg_wdata[1:0]);
        dst_w    <= wclamp(reg_wdata[3:2]);
        src_inc  <= reg_wdata[4];
        dst_inc  <= reg_wdata[5];
        mode     <= (reg_wdata[7:6] == 2'd3) ? 2'd0 : reg_wdata[7:6];
        burst_m1 <= reg_wdata[8 +: BW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsrc <= '0; rdst <= '0; rcnt <= '0;
    end else if (reg_we) begin
      if (reg_addr == 4'd5) rsrc <= reg_wdata[AW-1:0];
      if (reg_addr == 4'd6) rdst <= reg_wdata[AW-1:0];
      if (reg_addr == 4'd7) rcnt <= reg_wdata[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src <= '0; dst <= '0; cnt <= '0; hold <= '0;
    end else begin
      if (idle && reg_we && reg_addr == 4'd2) src <= reg_wdata[AW-1:0];
      else if (reload_go) src <= rsrc;
      else if (rd_done && src_inc && mode != 2'd1) src <= src + AW'(sb);

      if (idle && reg_we && reg_addr == 4'd3) dst <= reg_wdata[AW-1:0];
      else if (reload_go) dst <= rdst;
      else if (wr_done && dst_inc && mode != 2'd2) dst <= dst + AW'(db);

      if (idle && reg_we && reg_addr == 4'd4) cnt <= reg_wdata[CW-1:0];
      else if (wr_done) cnt <= reload_go ? rcnt : cnt_next;

      if (rd_done) hold <= bus_rdata & wmask(src_w);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_ctz <= 1'b0; f_dis <= 1'b0;
    end else begin
      f_ctz <= (wr_done && last) | (f_ctz & ~(wr_flags & reg_wdata[0]));
      f_dis <= stop_cmd | (idle && start_cmd && cnt == '0) | finish
             | (f_dis & ~(wr_flags & reg_wdata[1]));
    end
  end

  assign bus_req   = (st == S_RD) || (st == S_WR);
  assign bus_we    = (st == S_WR);
  assign bus_size  = bus_we ? dst_w : src_w;
  assign bus_addr  = bus_we ? ((mode == 2'd2) ? PORT_ADDR : dst)
                            : ((mode == 2'd1) ? PORT_ADDR : src);
  assign bus_wdata = hold & wmask(dst_w);
  assign irq       = (f_ctz & ctz_ie) | (f_dis & dis_ie);

  always_comb begin
    case (reg_addr)
      4'd0: reg_rdata = {14'd0, dis_ie, ctz_ie, 3'd0, 5'(burst_m1), mode, dst_inc, src_inc, dst_w, src_w};
      4'd1: reg_rdata = {31'd0, !idle};
      4'd2: reg_rdata = 32'(src);
      4'd3: reg_rdata = 32'(dst);
      4'd4: reg_rdata = 32'(cnt);
      4'd5: reg_rdata = 32'(rsrc);
      4'd6: reg_rdata = 32'(rdst);
      4'd7: reg_rdata = 32'(rcnt);
      4'd8: reg_rdata = {30'd0, f_dis, f_ctz};
      default: reg_rdata = '0;
    endcase
  end

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt && !stop_cmd) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_size)));

  assert_rd_then_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_gnt && !stop_cmd) |=> (bus_req && bus_we));

  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && last && rcnt != '0 && !stop_cmd) |=> (cnt == $past(rcnt) && !idle));

  assert_final_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && last && rcnt == '0) |=> (!bus_req && f_ctz && f_dis));

  assert_wait_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && !per_req && !stop_cmd) |=> !bus_req);

  assert_stop_drops_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cmd |=> (!bus_req && f_dis));

  assert_zero_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cmd && idle && cnt == '0) |=> (f_dis && !bus_req));
endmodule

// File: tb/dma_reload_chan_tb.sv
module dma_reload_chan_tb;
  localparam logic [31:0] PORT = 32'h4000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic per_req = 1'b0;
  logic bus_req, bus_we;
  logic [31:0] bus_addr;
  logic [1:0] bus_size;
  logic [31:0] bus_wdata;
  logic bus_gnt = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic irq;

  logic [7:0] mem [0:1023];
  logic [7:0] emem [0:1023];
  int runs = 0, fails = 0;
  int wait_left = 0;
  bit fixed_wait = 1'b0;
  logic [31:0] port_rd_val = '0;
  logic [31:0] port_wr_last = '0;
  int port_wr_cnt = 0, port_rd_cnt = 0, txn_cnt = 0;

  always #4 clk = ~clk;

  dma_reload_chan u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .per_req(per_req),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_gnt(bus_gnt), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic int nb(input int w);
    return (w == 0) ? 1 : (w == 1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] mkcfg(input int sw, dw, si, di, md, bm1, cie, die);
    return 32'(sw) | (32'(dw) << 2) | (32'(si) << 4) | (32'(di) << 5) | (32'(md) << 6)
         | (32'(bm1) << 8) | (32'(cie) << 16) | (32'(die) << 17);
  endfunction

  always @(negedge clk) begin
    bus_gnt = 1'b0;
    if (rst_n && bus_req) begin
      if (wait_left > 0) wait_left--;
      else begin
        bus_gnt = 1'b1;
        txn_cnt++;
        wait_left = fixed_wait ? 0 : $urandom_range(0, 2);
        if (bus_we) begin
          if (bus_addr == PORT) begin
            port_wr_cnt++;
            port_wr_last = bus_wdata;
          end else
            for (int i = 0; i < nb(bus_size); i++) mem[(bus_addr + i) & 1023] = bus_wdata[8*i +: 8];
        end else begin
          if (bus_addr == PORT) begin
            bus_rdata = port_rd_val;
            port_rd_val++;
            port_rd_cnt++;
          end else begin
            bus_rdata = $urandom;
            for (int i = 0; i < nb(bus_size); i++) bus_rdata[8*i +: 8] = mem[(bus_addr + i) & 1023];
          end
        end
      end
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic prog(input logic [31:0] cfg, input int s, input int d, input int c);
    wr(4'd0, cfg); wr(4'd2, 32'(s)); wr(4'd3, 32'(d)); wr(4'd4, 32'(c)); wr(4'd8, 32'd3);
  endtask

  task automatic wait_flag(input int bitn, input string req);
    logic [31:0] v;
    int t = 0;
    do begin
      @(negedge clk);
      rd(4'd8, v);
      t++;
    end while (!v[bitn] && t < 3000);
    if (t >= 3000) check(req, "flag wait timeout", 32'd0, 32'd1);
  endtask

  task automatic model_run(input int s, input int d, input int c, input int sw, input int dw,
                           input bit si, input bit di, output int fs, output int fd);
    logic [31:0] v;
    while (c > 0) begin
      v = '0;
      for (int i = 0; i < nb(sw); i++) v[8*i +: 8] = emem[(s + i) & 1023];
      for (int i = 0; i < nb(dw); i++) emem[(d + i) & 1023] = v[8*i +: 8];
      if (si) s += nb(sw);
      if (di) d += nb(dw);
      c = (c <= nb(dw)) ? 0 : c - nb(dw);
    end
    fs = s; fd = d;
  endtask

  task automatic cmp_mem(input string req);
    int bad = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== emem[i]) bad++;
    check(req, "memory bytes differing from model", 32'(bad), 32'd0);
  endtask

  task automatic sync_mem();
    for (int i = 0; i < 1024; i++) emem[i] = mem[i];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; runs++;
    $display("FAIL watchdog: got hung expected done");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int fs, fd, seen;
    void'($urandom(32'd7321));
    for (int i = 0; i < 1024; i++) begin mem[i] = 8'($urandom); emem[i] = mem[i]; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(4'd4, v); check("R1", "count after reset", v, 32'd0);
    rd(4'd8, v); check("R1", "flags after reset", v, 32'd0);
    rd(4'd1, v); check("R1", "running after reset", v, 32'd0);
    rd(4'd2, v); check("R1", "src after reset", v, 32'd0);
    check("R1", "irq/bus_req after reset", {30'd0, irq, bus_req}, 32'd0);

    // R10: start with zero count
    prog(32'd0, 0, 0, 0);
    v2 = 32'(txn_cnt);
    wr(4'd1, 32'd1);
    rd(4'd8, v); check("R10", "flags after zero-count start", v, 32'd2);
    seen = 0;
    repeat (5) begin @(negedge clk); if (bus_req) seen++; end
    check("R10", "bus requests after zero-count start", 32'(seen) + 32'(txn_cnt) - v2, 32'd0);

    // R12: interrupt masking
    #1 check("R12", "irq with enables off", {31'd0, irq}, 32'd0);
    wr(4'd0, 32'd1 << 17); #1 check("R12", "irq with disable-enable on", {31'd0, irq}, 32'd1);
    wr(4'd0, 32'd1 << 16); #1 check("R12", "irq with only ctz enable", {31'd0, irq}, 32'd0);
    wr(4'd0, 32'd1 << 17); wr(4'd8, 32'd2);
    rd(4'd8, v); check("R11", "flags after clear", v, 32'd0);
    check("R12", "irq after clear", {31'd0, irq}, 32'd0);

    // R11: clear in the same cycle as the flag set
    fixed_wait = 1'b1; wait_left = 0;
    prog(mkcfg(0, 0, 1, 1, 0, 0, 0, 0), 10, 600, 1);
    wr(4'd1, 32'd1);
    wr(4'd8, 32'd3);
    rd(4'd8, v); check("R11", "flags after colliding clear", v, 32'd3);
    model_run(10, 600, 1, 0, 0, 1, 1, fs, fd);
    cmp_mem("R11");

    // R9: stop in the same cycle as the final write grant
    wait_left = 0;
    prog(mkcfg(0, 0, 1, 1, 0, 0, 0, 0), 11, 601, 1);
    wr(4'd1, 32'd1);
    wr(4'd1, 32'd2);
    rd(4'd8, v); check("R9", "flags after stop on final grant", v, 32'd3);
    rd(4'd4, v); check("R9", "count after stop on final grant", v, 32'd0);
    rd(4'd1, v); check("R9", "running after stop on final grant", v, 32'd0);
    model_run(11, 601, 1, 0, 0, 1, 1, fs, fd);
    cmp_mem("R9");
    fixed_wait = 1'b0;

    // R2/R3/R4/R6: directed and random memory-to-memory runs
    for (int i = 0; i < 10; i++) begin
      int sw, dw, c, s, d;
      bit si, di;
      sw = (i == 0) ? 2 : (i == 1) ? 0 : $urandom_range(0, 2);
      dw = (i == 0) ? 0 : (i == 1) ? 2 : $urandom_range(0, 2);
      c  = (i == 0) ? 3 : (i == 1) ? 6 : $urandom_range(1, 40);
      si = (i < 2) ? 1'b1 : 1'($urandom);
      di = (i < 2) ? 1'b1 : 1'($urandom);
      s  = $urandom_range(0, 255);
      d  = 512 + $urandom_range(0, 127);
      prog(mkcfg(sw, dw, si, di, 0, 0, 0, 0), s, d, c);
      wr(4'd1, 32'd1);
      wait_flag(1, "R6");
      model_run(s, d, c, sw, dw, si, di, fs, fd);
      cmp_mem("R2");
      rd(4'd2, v); check("R3", "final source pointer", v, 32'(fs));
      rd(4'd3, v); check("R3", "final destination pointer", v, 32'(fd));
      rd(4'd4, v); check("R4", "final count", v, 32'd0);
      rd(4'd8, v); check("R6", "flags at natural end", v, 32'd3);
      check("R6", "bus_req after end", {31'd0, bus_req}, 32'd0);
    end

    // R5: reload continues, then disable reload
    prog(mkcfg(2, 2, 1, 1, 0, 0, 0, 0), 0, 700, 8);
    wr(4'd5, 32'd100); wr(4'd6, 32'd800); wr(4'd7, 32'd12);
    wr(4'd1, 32'd1);
    wait_flag(0, "R5");
    rd(4'd8, v); check("R5", "disable flag at reload", v[1], 1'b0);
    rd(4'd1, v); check("R5", "running after reload", v, 32'd1);
    wr(4'd7, 32'd0);
    wait_flag(1, "R5");
    model_run(0, 700, 8, 2, 2, 1, 1, fs, fd);
    model_run(100, 800, 12, 2, 2, 1, 1, fs, fd);
    cmp_mem("R5");
    rd(4'd2, v); check("R5", "source after reloaded segment", v, 32'd112);
    rd(4'd3, v); check("R5", "destination after reloaded segment", v, 32'd812);

    // R13 and R9: writes during run, then stop mid-transfer
    fixed_wait = 1'b1; wait_left = 0;
    prog(mkcfg(0, 0, 1, 1, 0, 0, 0, 0), 0, 512, 200);
    wr(4'd1, 32'd1);
    repeat (6) @(negedge clk);
    wr(4'd2, 32'h55); wr(4'd4, 32'd5); wr(4'd0, mkcfg(2, 2, 0, 0, 1, 3, 0, 0)); wr(4'd7, 32'd9);
    rd(4'd2, v); check("R13", "source write ignored while running", {31'd0, v == 32'h55}, 32'd0);
    rd(4'd4, v); check("R13", "count write ignored while running", {31'd0, v == 32'd5}, 32'd0);
    rd(4'd0, v); check("R13", "config write ignored while running", v, mkcfg(0, 0, 1, 1, 0, 0, 0, 0));
    rd(4'd7, v); check("R13", "reload count writable while running", v, 32'd9);
    rd(4'd1, v); check("R13", "still running", v, 32'd1);
    wr(4'd1, 32'd2);
    #1 check("R9", "bus_req after stop", {31'd0, bus_req}, 32'd0);
    rd(4'd1, v); check("R9", "running after stop", v, 32'd0);
    rd(4'd8, v); check("R9", "flags after stop", v, 32'd2);
    rd(4'd4, v2);
    rd(4'd3, v); check("R9", "destination matches bytes moved", v, 32'd512 + 32'd200 - v2);
    rd(4'd2, v); check("R9", "source within one unit of writes", {31'd0, (v - (32'd200 - v2)) <= 1}, 32'd1);
    seen = 0;
    repeat (5) begin @(negedge clk); if (bus_req) seen++; end
    check("R9", "bus requests after stop", 32'(seen), 32'd0);
    model_run(0, 512, 200 - int'(v2), 0, 0, 1, 1, fs, fd);
    cmp_mem("R9");
    wr(4'd7, 32'd0);
    fixed_wait = 1'b0;

    // R7/R8: peripheral to memory, bursts of 8 bytes
    port_rd_val = 32'hA000_0000; port_rd_cnt = 0;
    prog(mkcfg(2, 2, 1, 1, 1, 7, 0, 0), 32'h12, 900, 16);
    v2 = 32'(txn_cnt);
    wr(4'd1, 32'd1);
    repeat (6) @(negedge clk);
    check("R8", "transactions without request", 32'(txn_cnt) - v2, 32'd0);
    per_req = 1'b1; @(negedge clk); per_req = 1'b0;
    repeat (14) @(negedge clk);
    rd(4'd4, v); check("R8", "count after one burst", v, 32'd8);
    check("R7", "port reads after one burst", 32'(port_rd_cnt), 32'd2);
    per_req = 1'b1; @(negedge clk); per_req = 1'b0;
    wait_flag(1, "R8");
    for (int k = 0; k < 4; k++)
      check("R7", "word from port", {mem[903+4*k], mem[902+4*k], mem[901+4*k], mem[900+4*k]}, 32'hA000_0000 + 32'(k));
    rd(4'd2, v); check("R7", "port-side source pointer fixed", v, 32'h12);
    rd(4'd3, v); check("R7", "destination after port transfer", v, 32'd916);
    sync_mem();

    // R7: memory to peripheral with request held
    port_wr_cnt = 0;
    prog(mkcfg(1, 1, 1, 1, 2, 1, 0, 0), 40, 32'h77, 4);
    per_req = 1'b1;
    wr(4'd1, 32'd1);
    wait_flag(1, "R7");
    per_req = 1'b0;
    check("R7", "port writes", 32'(port_wr_cnt), 32'd2);
    check("R7", "last port write", port_wr_last, {16'd0, mem[43], mem[42]});
    rd(4'd3, v); check("R7", "port-side destination fixed", v, 32'h77);
    rd(4'd2, v); check("R7", "source after port writes", v, 32'd44);
    rd(4'd8, v); check("R6", "flags after port writes", v, 32'd3);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule